// File: doc/BRIEF.md
# SDRAM Bank-Row-Column Access Sequencer

This block turns one linear word address plus a read or write request into the command sequence that a synchronous DRAM needs for a single burst access. It splits the address into bank, row and column according to a selectable device density. It then opens the row with an activate command, waits the row-to-column delay, and issues the read or write with the starting column. After a burst-completion delay it closes the bank with a single-bank precharge. Only one row is open at a time, and every access ends with a precharge.

Requests arrive over a valid/ready handshake. Ready stays low from the edge that accepts a request until the precharge recovery time has passed, so a new request can never disturb an access in flight. All command and address outputs come from registers, so the device sees stable values at its rising clock edge. Data capture, refresh and power-up initialization belong to other blocks.

Top module: `sdram_access_seq`

## Requirements
- R1: While reset is held, and after reset is released, the outputs show NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1) with ba and a all zero. req_ready is low during reset and rises on the third rising clock edge after rst_n goes high.
- R2: A request is accepted at a rising edge where req_valid and req_ready are both high. From that edge the outputs show ACTIVE (0,0,1,1).
- R3: The linear address is split with the column in the lowest bits, the 2-bit bank above it and the row above that. For geometry 0 the split is 10 column bits and 12 row bits. For geometry 1 it is 11 column bits and 12 row bits. For geometry 2 and 3 it is 11 column bits and 13 row bits. Higher address bits are ignored. ba carries the bank during ACTIVE, READ/WRITE and PRECHARGE.
- R4: READ (0,1,0,1) for req_write=0 or WRITE (0,1,0,0) for req_write=1 is shown exactly T_RCD edges after ACTIVE, on the same bank.
- R5: During READ/WRITE, a[9:0] carries column bits 9..0 and a[10] is low (no auto-precharge). a[11] carries column bit 10 for geometries 1 to 3 and is low for geometry 0. a[12] is low.
- R6: During ACTIVE, a[11:0] carries row bits 11..0. a[12] carries row bit 12 for geometries 2 and 3 and is low otherwise.
- R7: PRECHARGE (0,0,1,0) is shown exactly T_BURST edges after READ/WRITE. ba holds the accessed bank and a is all zero, so a[10] is low and only that bank is precharged.
- R8: req_ready falls at the accepting edge and rises again exactly T_RP edges after the edge that shows PRECHARGE.
- R9: Every cycle that carries none of the commands above shows NOP with ba and a zero.
- R10: While req_ready is low, changes on req_valid, req_write, req_addr and req_geo have no effect on the command, bank or address outputs of the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 26 | Linear word address |
| req_geo | input | 2 | Density select: 0 small, 1 mid, 2 and 3 large |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| a | output | 13 | Multiplexed row/column address |

## Verification
The bench targets the column bit that jumps over a[10] at every density. A wrong pin map would put column bit 10 on the auto-precharge pin, or drive a[11] for the small density. It uses addresses with row bit 12 set and with junk in the high bits. These show a row width that does not follow the geometry, or a bank taken from the wrong bit slice. It holds req_valid high during accesses and scrambles address, density and direction. A design that does not latch its request at acceptance would change bank or column mid-access, or start a second ACTIVE before the precharge wait ends. Back-to-back requests check that the ready gap is exactly T_RP after PRECHARGE and not one edge short.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int BA_W        = 2;
  localparam int A_W         = 13;
  localparam int COL_W_SMALL = 10;
  localparam int COL_W_BIG   = 11;
  localparam int ROW_W_MID   = 12;
  localparam int ROW_W_BIG   = 13;
  localparam int LIN_W       = COL_W_BIG + BA_W + ROW_W_BIG;
  localparam int AP_BIT      = 10;

  // Command encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RCD,
    ST_BURST,
    ST_RP
  } seq_st_e;
endpackage

// File: rtl/sdram_addr_map.sv
module sdram_addr_map
  import sdram_seq_pkg::*;
(
  input  logic [LIN_W-1:0] lin_addr,
  input  logic [1:0]       geo,
  output logic [BA_W-1:0]  bank,
  output logic [A_W-1:0]   row_pins,
  output logic [A_W-1:0]   col_pins
);
  logic [COL_W_BIG-1:0] col;
  logic [ROW_W_BIG-1:0] row;
  logic                 wide_col;
  logic                 tall_row;

  always_comb begin
    wide_col = (geo != 2'd0);
    tall_row = geo[1];
    if (!wide_col) begin
      col  = COL_W_BIG'(lin_addr[COL_W_SMALL-1:0]);
      bank = lin_addr[COL_W_SMALL +: BA_W];
      row  = ROW_W_BIG'(lin_addr[COL_W_SMALL+BA_W +: ROW_W_MID]);
    end else begin
      col  = lin_addr[COL_W_BIG-1:0];
      bank = lin_addr[COL_W_BIG +: BA_W];
      if (tall_row) row = lin_addr[COL_W_BIG+BA_W +: ROW_W_BIG];
      else          row = ROW_W_BIG'(lin_addr[COL_W_BIG+BA_W +: ROW_W_MID]);
    end
    row_pins = A_W'(row);
    // column skips the auto-precharge pin
    col_pins = '0;
    col_pins[AP_BIT-1:0] = col[AP_BIT-1:0];
    col_pins[AP_BIT+1]   = col[AP_BIT];
  end
endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int T_RCD   = 3,
  parameter int T_BURST = 4,
  parameter int T_RP    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic ready,
  output logic accept,
  output cmd_e cmd_next
);
  localparam int T_MAX = (T_RCD > T_BURST) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                           : ((T_BURST > T_RP) ? T_BURST : T_RP);
  localparam int CNT_W = $clog2(T_MAX + 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic             rdy_q, rdy_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    wr_d     = wr_q;
    cmd_next = CMD_NOP;
    accept   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid && rdy_q) begin
          accept   = 1'b1;
          st_d     = ST_RCD;
          cnt_d    = CNT_W'(T_RCD - 1);
          wr_d     = req_write;
          cmd_next = CMD_ACT;
        end
      end
      ST_RCD: begin
        if (cnt_q == '0) begin
          st_d     = ST_BURST;
          cnt_d    = CNT_W'(T_BURST - 1);
          cmd_next = wr_q ? CMD_WR : CMD_RD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_BURST: begin
        if (cnt_q == '0) begin
          st_d     = ST_RP;
          cnt_d    = CNT_W'(T_RP - 1);
          cmd_next = CMD_PRE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) st_d = ST_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
    endcase
    rdy_d = (st_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      wr_q  <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      wr_q  <= wr_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/sdram_access_seq.sv
module sdram_access_seq
  import sdram_seq_pkg::*;
#(
  parameter int T_RCD   = 3,
  parameter int T_BURST = 4,
  parameter int T_RP    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [LIN_W-1:0] req_addr,
  input  logic [1:0]       req_geo,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [A_W-1:0]   a
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [BA_W-1:0] map_bank;
  logic [A_W-1:0]  map_row;
  logic [A_W-1:0]  map_col;
  logic            accept;
  cmd_e            cmd_next;
  logic [BA_W-1:0] bank_q;
  logic [A_W-1:0]  col_q;
  cmd_e            cmd_q;
  logic [BA_W-1:0] ba_q, ba_d;
  logic [A_W-1:0]  a_q, a_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdram_addr_map u_map (
    .lin_addr (req_addr),
    .geo      (req_geo),
    .bank     (map_bank),
    .row_pins (map_row),
    .col_pins (map_col)
  );

  sdram_seq_fsm #(
    .T_RCD   (T_RCD),
    .T_BURST (T_BURST),
    .T_RP    (T_RP)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .ready     (req_ready),
    .accept    (accept),
    .cmd_next  (cmd_next)
  );

  // request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bank_q <= '0;
      col_q  <= '0;
    end else if (accept) begin
      bank_q <= map_bank;
      col_q  <= map_col;
    end
  end

  always_comb begin
    ba_d = '0;
    a_d  = '0;
    case (cmd_next)
      CMD_ACT: begin
        ba_d = map_bank;
        a_d  = map_row;
      end
      CMD_RD, CMD_WR: begin
        ba_d = bank_q;
        a_d  = col_q;
      end
      CMD_PRE: ba_d = bank_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q <= CMD_NOP;
      ba_q  <= '0;
      a_q   <= '0;
    end else begin
      cmd_q <= cmd_next;
      ba_q  <= ba_d;
      a_q   <= a_d;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba = ba_q;
  assign a  = a_q;
endmodule

// File: rtl/sdram_access_seq_chk.sv
module sdram_access_seq_chk #(
  parameter int T_RCD   = 3,
  parameter int T_BURST = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [12:0] a
);
  logic [3:0] cmd;
  logic       is_act, is_rw, is_pre, is_nop;
  logic [7:0] since_act_q, since_rw_q;
  logic [1:0] act_bank_q;

  assign cmd    = {cs_n, ras_n, cas_n, we_n};
  assign is_act = (cmd == 4'b0011);
  assign is_rw  = (cmd == 4'b0101) || (cmd == 4'b0100);
  assign is_pre = (cmd == 4'b0010);
  assign is_nop = (cmd == 4'b0111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act_q <= '0;
      since_rw_q  <= '0;
      act_bank_q  <= '0;
    end else begin
      if (is_act) begin
        since_act_q <= 8'd1;
        act_bank_q  <= ba;
      end else if (since_act_q != '0 && since_act_q != 8'hFF) begin
        since_act_q <= since_act_q + 8'd1;
      end
      if (is_rw) since_rw_q <= 8'd1;
      else if (since_rw_q != '0 && since_rw_q != 8'hFF) since_rw_q <= since_rw_q + 8'd1;
    end
  end

  a_r2_act_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> is_act);

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_no_act_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> !is_act);

  // R4: column command exactly T_RCD edges after ACTIVE, same bank
  a_r4_rw_timing: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (since_act_q == 8'(T_RCD)) && (ba == act_bank_q));

  a_r5_no_autoprecharge: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (a[10] == 1'b0) && (a[12] == 1'b0));

  // R7: precharge T_BURST edges after the column command, bank kept
  a_r7_pre_timing: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_rw_q == 8'(T_BURST)) && (ba == act_bank_q) && (a == '0));

  a_r9_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |-> (ba == '0) && (a == '0));

  a_r9_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop || is_act || is_rw || is_pre);
endmodule

bind sdram_access_seq sdram_access_seq_chk #(
  .T_RCD   (T_RCD),
  .T_BURST (T_BURST)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .a         (a)
);

// File: tb/sdram_access_seq_tb.sv
`timescale 1ns/1ps
module sdram_access_seq_tb;
  localparam int T_RCD   = 3;
  localparam int T_BURST = 4;
  localparam int T_RP    = 3;
  localparam int LEN     = T_RCD + T_BURST + T_RP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [1:0]  req_geo = '0;
  logic        req_ready;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] a;

  always #4 clk = ~clk;

  sdram_access_seq #(.T_RCD(T_RCD), .T_BURST(T_BURST), .T_RP(T_RP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_geo(req_geo),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a(a)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] a;
    logic        rdy;
  } exp_t;

  exp_t exp_q[$];
  logic [3:0]  e_cmd = 4'b0111;
  logic [1:0]  e_ba = '0;
  logic [12:0] e_a = '0;
  logic        e_rdy = 1'b0;
  logic        acc_flag = 1'b0;
  logic        cmp_en = 1'b0;
  bit          noise_on = 1'b0;
  int          rcnt = 0;
  int          vectors = 0;
  int          fails = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  // behavioural address split and pin placement
  function automatic void split(input logic [25:0] ad, input logic [1:0] g,
                                output int bk, output int rw, output int cl);
    int cb, rb;
    cb = (g == 2'd0) ? 10 : 11;
    rb = (g >= 2'd2) ? 13 : 12;
    cl = int'(ad) % (1 << cb);
    bk = (int'(ad) >> cb) % 4;
    rw = (int'(ad) >> (cb + 2)) % (1 << rb);
  endfunction

  // model: sampled inputs at each rising edge, expected outputs after it
  always @(posedge clk) begin
    int bk, rw, cl, colpins;
    exp_t ent;
    acc_flag = 1'b0;
    if (!rst_n) begin
      exp_q.delete();
      rcnt = 0;
      e_cmd = 4'b0111; e_ba = '0; e_a = '0; e_rdy = 1'b0;
    end else begin
      cmp_en = 1'b1;
      rcnt++;
      if (exp_q.size() != 0) begin
        ent = exp_q.pop_front();
        e_cmd = ent.cmd; e_ba = ent.ba; e_a = ent.a; e_rdy = ent.rdy;
      end else if (req_valid && e_rdy) begin
        acc_flag = 1'b1;
        split(req_addr, req_geo, bk, rw, cl);
        colpins = (cl % 1024) + ((cl / 1024) * 2048);
        e_cmd = 4'b0011; e_ba = 2'(bk); e_a = 13'(rw); e_rdy = 1'b0;
        for (int k = 1; k <= LEN; k++) begin
          ent.rdy = (k == LEN);
          if (k == T_RCD) begin
            ent.cmd = req_write ? 4'b0100 : 4'b0101;
            ent.ba = 2'(bk); ent.a = 13'(colpins);
          end else if (k == T_RCD + T_BURST) begin
            ent.cmd = 4'b0010; ent.ba = 2'(bk); ent.a = '0;
          end else begin
            ent.cmd = 4'b0111; ent.ba = '0; ent.a = '0;
          end
          exp_q.push_back(ent);
        end
      end else begin
        e_cmd = 4'b0111; e_ba = '0; e_a = '0;
        e_rdy = (rcnt >= 3);
      end
    end
  end

  function automatic string tag_cmd(input logic [3:0] c);
    case (c)
      4'b0011: return "R2";
      4'b0101, 4'b0100: return "R4";
      4'b0010: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic string tag_a(input logic [3:0] c);
    case (c)
      4'b0011: return "R6";
      4'b0101, 4'b0100: return "R5";
      4'b0010: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // comparison away from the active edge
  always @(negedge clk) begin
    string pre;
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
      report();
    end
    if (cmp_en && !done) begin
      pre = (rcnt < 3) ? "R1 " : (noise_on ? "R10 " : "");
      vectors++;
      if ({cs_n, ras_n, cas_n, we_n} !== e_cmd) begin
        fails++;
        $display("FAIL %s%s cmd: actual %b expected %b", pre, tag_cmd(e_cmd),
                 {cs_n, ras_n, cas_n, we_n}, e_cmd);
      end
      if (ba !== e_ba) begin
        fails++;
        $display("FAIL %sR3 ba: actual %0d expected %0d", pre, ba, e_ba);
      end
      if (a !== e_a) begin
        fails++;
        $display("FAIL %s%s a: actual %h expected %h", pre, tag_a(e_cmd), a, e_a);
      end
      if (req_ready !== e_rdy) begin
        fails++;
        $display("FAIL %sR8 ready: actual %b expected %b", pre, req_ready, e_rdy);
      end
    end
  end

  // one request; optional scrambled inputs while busy (R10)
  task automatic req(input logic w, input logic [25:0] ad, input logic [1:0] g,
                     input bit noise);
    req_valid = 1'b1; req_write = w; req_addr = ad; req_geo = g;
    do @(negedge clk); while (!acc_flag);
    req_valid = 1'b0;
    noise_on = noise;
    forever begin
      if (e_rdy) begin
        req_valid = 1'b0;
        noise_on = 1'b0;
        break;
      end
      if (noise) begin
        req_valid = 1'b1;
        req_write = 1'($urandom);
        req_addr  = 26'($urandom);
        req_geo   = 2'($urandom);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;                      // R1: reset release, ready after third edge
    repeat (6) @(negedge clk);
    // R3 R5 R6: small density, junk in high bits, all column bits set
    req(1'b0, 26'h3FF_FFFF, 2'd0, 1'b0);
    // R5: mid density, column bit 10 moves to a[11]
    req(1'b1, {12'hA5C, 2'd2, 11'h400}, 2'd1, 1'b0);
    // R6: large density, row bit 12 on a[12]
    req(1'b0, {13'h1003, 2'd1, 11'h2AA}, 2'd2, 1'b0);
    // geometry 3 behaves as large
    req(1'b1, {13'h1FFF, 2'd3, 11'h7FF}, 2'd3, 1'b0);
    // R10: scrambled inputs while busy
    req(1'b1, {13'h0F0F, 2'd2, 11'h155}, 2'd2, 1'b1);
    req(1'b0, {12'h001, 2'd1, 10'h3FF}, 2'd0, 1'b1);
    // R8: back-to-back requests accepted on the first ready edge
    for (int i = 0; i < 12; i++) begin
      req(1'($urandom), 26'($urandom), 2'($urandom), (i % 3) == 0);
    end
    repeat (5) @(negedge clk);
    report();
  end
endmodule